// File: doc/BRIEF.md
# Hardware Cursor Overlay Compositor

The block sits in a display pixel stream and paints a small pointer image over it. Each incoming raster pixel carries its own x/y coordinates. The block compares them against a signed cursor origin and a selected cursor edge length of 32 or 64 pixels. Pixels that land inside the cursor window are replaced according to a two-bit code. That code is built from a mask plane and a color plane, each holding one bit per cursor pixel. The result can be the untouched pixel, its bitwise inverse, or one of two programmed RGB888 colors. Everything else passes through. The path is a single register stage, and the coordinates travel with the pixel.

The cursor image is loaded one 32-bit word at a time through a write port. The port selects a plane, a row and a word within the row. Writes collect in a shadow copy. A two-state controller tracks whether the shadow holds changes that are not yet shown. Its states are ST_CLEAN (nothing pending) and ST_DIRTY (shadow differs from the shown image). A write moves ST_CLEAN to ST_DIRTY. When the first pixel of a frame arrives in ST_DIRTY, the shadow is copied into the shown image. The state then returns to ST_CLEAN, or stays in ST_DIRTY when a write lands in that same cycle. Because of this, a half-written image is never displayed.

Top module: `cursor_overlay`

## Requirements
- R1: `out_valid`, `out_x`, `out_y` and `out_rgb` present the result for an input pixel exactly one clock after it is accepted with `in_valid`=1. `out_valid` is 0 in every cycle following one with `in_valid`=0.
- R2: Inside the cursor, mask=1 with color=0 passes the input pixel unchanged, and mask=1 with color=1 outputs the bitwise inverse of all 24 input bits.
- R3: Inside the cursor, mask=0 with color=0 outputs `bg_rgb`, and mask=0 with color=1 outputs `fg_rgb`. Colors are packed R in [23:16], G in [15:8], B in [7:0].
- R4: Bitmap writes select the plane with `bm_wr_plane` (1 = mask, 0 = color), the cursor row with `bm_wr_row`, and the word with `bm_wr_word`. Bit j of word w holds cursor column 32*w+j of that row.
- R5: A pixel uses cursor data only when 0 <= x - cur_x < size and 0 <= y - cur_y < size. The comparison uses signed `cur_x`/`cur_y`, so a cursor partly off the left or top edge is clipped. Column and row are those differences.
- R6: `size_sel`=01 selects a 32x32 cursor and `size_sel`=10 selects 64x64. Values 00 and 11 make every pixel pass unchanged.
- R7: With `cur_visible`=0 every pixel passes unchanged.
- R8: Bitmap writes are not visible until a pixel with `in_valid`=1 and `in_sof`=1 arrives. That pixel already uses the updated image.
- R9: A write issued in the same cycle as a frame-start pixel is not part of that update. It becomes visible at the following frame start.
- R10: After reset, `out_valid` and `out_rgb` are 0. Both image copies hold mask=1 and color=0 everywhere, so a visible cursor is transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_rgb | input | 24 | Foreground color |
| bg_rgb | input | 24 | Background color |
| size_sel | input | 2 | Cursor size select (01 = 32, 10 = 64) |
| cur_x | input | 16 | Signed cursor origin x |
| cur_y | input | 16 | Signed cursor origin y |
| cur_visible | input | 1 | Overlay enable |
| bm_wr_en | input | 1 | Bitmap word write strobe |
| bm_wr_plane | input | 1 | 1 = mask plane, 0 = color plane |
| bm_wr_row | input | 6 | Cursor row written |
| bm_wr_word | input | 1 | Word within the row |
| bm_wr_data | input | 32 | Bitmap word |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_x | input | 16 | Raster x of input pixel |
| in_y | input | 16 | Raster y of input pixel |
| in_rgb | input | 24 | Underlying pixel color |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Raster x of output pixel |
| out_y | output | 16 | Raster y of output pixel |
| out_rgb | output | 24 | Composited pixel color |

## Verification
The image update and the image lookup can fall in the same cycle. A frame-start pixel inside the cursor must read the image that its own arrival commits, and a bitmap write can arrive on that same edge. The bench first changes a color word and sends a frame-start pixel over that word; the output must already show the new code. It then drives a write and a frame-start pixel on the same edge. The old image must still be shown, the written value must stay pending through one more non-start pixel, and it must appear only at the next frame start.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    // Two-bit pixel code: {mask bit, color bit}
    typedef enum logic [1:0] {
        CODE_BACK  = 2'b00,
        CODE_FORE  = 2'b01,
        CODE_CLEAR = 2'b10,
        CODE_INV   = 2'b11
    } cur_code_t;

    // Shadow update controller
    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_DIRTY = 1'b1
    } upd_state_t;

endpackage

// File: rtl/cursor_bitmap_store.sv
module cursor_bitmap_store
    import cursor_pkg::*;
#(
    parameter int MAX_DIM = 64,
    parameter int WORD_W  = 32,
    localparam int WORDS  = MAX_DIM / WORD_W,
    localparam int DEPTH  = MAX_DIM * WORDS,
    localparam int ROW_W  = $clog2(MAX_DIM),
    localparam int COL_W  = $clog2(MAX_DIM),
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_plane,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              commit,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output logic              rd_mask,
    output logic              rd_color
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sh_mask  [DEPTH];
    logic [WORD_W-1:0] sh_color [DEPTH];
    logic [WORD_W-1:0] act_mask [DEPTH];
    logic [WORD_W-1:0] act_color[DEPTH];

    upd_state_t state, state_nx;
    logic       copy_now;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN: if (wr_en) state_nx = ST_DIRTY;
            ST_DIRTY: if (commit && !wr_en) state_nx = ST_CLEAN;
            default:  state_nx = ST_CLEAN;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        copy_now = 1'b0;
        unique case (state)
            ST_CLEAN: copy_now = 1'b0;
            ST_DIRTY: copy_now = commit;
            default:  copy_now = 1'b0;
        endcase
    end

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [BIT_W-1:0] rd_bit;

    always_comb begin
        wr_idx = IDX_W'(int'(wr_row) * WORDS + int'(wr_word));
        rd_idx = IDX_W'(int'(rd_row) * WORDS + int'(rd_col) / WORD_W);
        rd_bit = BIT_W'(int'(rd_col) % WORD_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sh_mask[i]   <= '1;
                sh_color[i]  <= '0;
                act_mask[i]  <= '1;
                act_color[i] <= '0;
            end
        end else begin
            if (copy_now) begin
                for (int i = 0; i < DEPTH; i++) begin
                    act_mask[i]  <= sh_mask[i];
                    act_color[i] <= sh_color[i];
                end
            end
            if (wr_en) begin
                if (wr_plane) sh_mask[wr_idx]  <= wr_data;
                else          sh_color[wr_idx] <= wr_data;
            end
        end
    end

    // A committing pixel reads the shadow so it already sees the new image
    logic [WORD_W-1:0] m_word, c_word;
    always_comb begin
        m_word   = copy_now ? sh_mask[rd_idx]  : act_mask[rd_idx];
        c_word   = copy_now ? sh_color[rd_idx] : act_color[rd_idx];
        rd_mask  = m_word[rd_bit];
        rd_color = c_word[rd_bit];
    end

endmodule

// File: rtl/cursor_hit_test.sv
module cursor_hit_test #(
    parameter int COORD_W   = 16,
    parameter int MAX_DIM   = 64,
    parameter int SMALL_DIM = 32,
    localparam int COL_W    = $clog2(MAX_DIM),
    localparam int D_W      = COORD_W + 2
) (
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic [1:0]         size_sel,
    input  logic               visible,
    output logic               hit,
    output logic [COL_W-1:0]   col,
    output logic [COL_W-1:0]   row
);

    logic signed [D_W-1:0] dx, dy, lim;
    logic                  size_ok;

    always_comb begin
        dx      = $signed({2'b00, px}) - $signed({{2{cx[COORD_W-1]}}, cx});
        dy      = $signed({2'b00, py}) - $signed({{2{cy[COORD_W-1]}}, cy});
        size_ok = (size_sel == 2'b01) || (size_sel == 2'b10);
        lim     = size_sel[1] ? D_W'(MAX_DIM) : D_W'(SMALL_DIM);
        hit     = visible && size_ok &&
                  (dx >= 0) && (dx < lim) &&
                  (dy >= 0) && (dy < lim);
        col     = dx[COL_W-1:0];
        row     = dy[COL_W-1:0];
    end

endmodule

// File: rtl/cursor_pixel_mux.sv
module cursor_pixel_mux
    import cursor_pkg::*;
#(
    parameter int RGB_W = 24
) (
    input  logic             hit,
    input  logic             mask_bit,
    input  logic             color_bit,
    input  logic [RGB_W-1:0] under,
    input  logic [RGB_W-1:0] fg,
    input  logic [RGB_W-1:0] bg,
    output logic [RGB_W-1:0] pix
);

    cur_code_t code;

    always_comb begin
        code = cur_code_t'({mask_bit, color_bit});
        pix  = under;
        if (hit) begin
            unique case (code)
                CODE_BACK:  pix = bg;
                CODE_FORE:  pix = fg;
                CODE_CLEAR: pix = under;
                CODE_INV:   pix = ~under;
                default:    pix = under;
            endcase
        end
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int COORD_W   = 16,
    parameter int MAX_DIM   = 64,
    parameter int SMALL_DIM = 32,
    parameter int WORD_W    = 32,
    parameter int RGB_W     = 24,
    localparam int ROW_W    = $clog2(MAX_DIM),
    localparam int WORDS    = MAX_DIM / WORD_W,
    localparam int WSEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RGB_W-1:0]   fg_rgb,
    input  logic [RGB_W-1:0]   bg_rgb,
    input  logic [1:0]         size_sel,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic               cur_visible,
    input  logic               bm_wr_en,
    input  logic               bm_wr_plane,
    input  logic [ROW_W-1:0]   bm_wr_row,
    input  logic [WSEL_W-1:0]  bm_wr_word,
    input  logic [WORD_W-1:0]  bm_wr_data,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [RGB_W-1:0]   in_rgb,
    output logic               out_valid,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y,
    output logic [RGB_W-1:0]   out_rgb
);

    logic             hit;
    logic [ROW_W-1:0] col, row;
    logic             m_bit, c_bit;
    logic [RGB_W-1:0] pix;

    cursor_hit_test #(
        .COORD_W  (COORD_W),
        .MAX_DIM  (MAX_DIM),
        .SMALL_DIM(SMALL_DIM)
    ) u_hit (
        .px      (in_x),
        .py      (in_y),
        .cx      (cur_x),
        .cy      (cur_y),
        .size_sel(size_sel),
        .visible (cur_visible),
        .hit     (hit),
        .col     (col),
        .row     (row)
    );

    cursor_bitmap_store #(
        .MAX_DIM(MAX_DIM),
        .WORD_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bm_wr_en),
        .wr_plane(bm_wr_plane),
        .wr_row  (bm_wr_row),
        .wr_word (bm_wr_word),
        .wr_data (bm_wr_data),
        .commit  (in_valid && in_sof),
        .rd_row  (row),
        .rd_col  (col),
        .rd_mask (m_bit),
        .rd_color(c_bit)
    );

    cursor_pixel_mux #(
        .RGB_W(RGB_W)
    ) u_mux (
        .hit      (hit),
        .mask_bit (m_bit),
        .color_bit(c_bit),
        .under    (in_rgb),
        .fg       (fg_rgb),
        .bg       (bg_rgb),
        .pix      (pix)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_x   <= in_x;
                out_y   <= in_y;
                out_rgb <= pix;
            end
        end
    end

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int COORD_W = 16,
    parameter int RGB_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         size_sel,
    input logic [COORD_W-1:0] cur_x,
    input logic               cur_visible,
    input logic               in_valid,
    input logic [COORD_W-1:0] in_x,
    input logic [COORD_W-1:0] in_y,
    input logic [RGB_W-1:0]   in_rgb,
    input logic               out_valid,
    input logic [COORD_W-1:0] out_x,
    input logic [COORD_W-1:0] out_y,
    input logic [RGB_W-1:0]   out_rgb
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1
    coord_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_x == $past(in_x)) && (out_y == $past(in_y)));

    // R7
    hidden_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cur_visible) |=> (out_rgb == $past(in_rgb)));

    // R6
    bad_size_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !$onehot(size_sel)) |=> (out_rgb == $past(in_rgb)));

    // R5
    left_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ($signed({1'b0, in_x}) < $signed({cur_x[COORD_W-1], cur_x})))
        |=> (out_rgb == $past(in_rgb)));

endmodule

bind cursor_overlay cursor_overlay_chk #(
    .COORD_W(COORD_W),
    .RGB_W  (RGB_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_sel   (size_sel),
    .cur_x      (cur_x),
    .cur_visible(cur_visible),
    .in_valid   (in_valid),
    .in_x       (in_x),
    .in_y       (in_y),
    .in_rgb     (in_rgb),
    .out_valid  (out_valid),
    .out_x      (out_x),
    .out_y      (out_y),
    .out_rgb    (out_rgb)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] fg_rgb = 24'hFF2010;
    logic [23:0] bg_rgb = 24'h0A0B0C;
    logic [1:0]  size_sel = 2'b01;
    logic [15:0] cur_x = 16'd100;
    logic [15:0] cur_y = 16'd50;
    logic        cur_visible = 1'b1;
    logic        bm_wr_en = 1'b0;
    logic        bm_wr_plane = 1'b0;
    logic [5:0]  bm_wr_row = '0;
    logic [0:0]  bm_wr_word = '0;
    logic [31:0] bm_wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic [23:0] in_rgb = '0;
    logic        out_valid;
    logic [15:0] out_x, out_y;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cursor_overlay dut (
        .clk(clk), .rst_n(rst_n), .fg_rgb(fg_rgb), .bg_rgb(bg_rgb),
        .size_sel(size_sel), .cur_x(cur_x), .cur_y(cur_y),
        .cur_visible(cur_visible), .bm_wr_en(bm_wr_en),
        .bm_wr_plane(bm_wr_plane), .bm_wr_row(bm_wr_row),
        .bm_wr_word(bm_wr_word), .bm_wr_data(bm_wr_data),
        .in_valid(in_valid), .in_sof(in_sof), .in_x(in_x), .in_y(in_y),
        .in_rgb(in_rgb), .out_valid(out_valid), .out_x(out_x),
        .out_y(out_y), .out_rgb(out_rgb)
    );

    // Expected kinds: 0 pass, 1 invert, 2 foreground, 3 background
    localparam int NV = 8;
    localparam logic [57:0] VEC [NV] = '{
        {16'd100, 16'd50, 24'h123456, 2'd1},  // col 0  : invert
        {16'd108, 16'd50, 24'h654321, 2'd0},  // col 8  : transparent
        {16'd116, 16'd60, 24'hABCDEF, 2'd2},  // col 16 : foreground
        {16'd131, 16'd81, 24'h00FF00, 2'd3},  // col 31 row 31 : background
        {16'd132, 16'd50, 24'h111111, 2'd0},  // right of 32x32
        {16'd99,  16'd50, 24'h222222, 2'd0},  // left of origin
        {16'd100, 16'd82, 24'h333333, 2'd0},  // below 32x32
        {16'd100, 16'd49, 24'h444444, 2'd0}   // above origin
    };

    function automatic logic [23:0] expect_of(input logic [1:0] kind, input logic [23:0] u);
        case (kind)
            2'd1:    return ~u;
            2'd2:    return fg_rgb;
            2'd3:    return bg_rgb;
            default: return u;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bm_write(input logic plane, input int row, input int word, input logic [31:0] d);
        @(negedge clk);
        bm_wr_en = 1'b1; bm_wr_plane = plane; bm_wr_row = 6'(row);
        bm_wr_word = 1'(word); bm_wr_data = d;
        @(negedge clk);
        bm_wr_en = 1'b0;
    endtask

    task automatic pixel(input int x, input int y, input logic [23:0] rgb, input logic sof,
                         input logic [1:0] kind, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_x = 16'(x); in_y = 16'(y); in_rgb = rgb;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; bm_wr_en = 1'b0;
        check(req, 32'(out_rgb), 32'(expect_of(kind, rgb)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid after reset", 32'(out_valid), 32'd0);
        check("R10 out_rgb after reset", 32'(out_rgb), 32'd0);
        rst_n = 1'b1;
        // R10 default image is transparent
        pixel(100, 50, 24'h5A5A5A, 1'b1, 2'd0, "R10 default image transparent");

        // Load image (R4): cols 0-7 invert, 8-15 clear, 16-23 fg, 24-31 bg, 32-63 fg
        for (int r = 0; r < 64; r++) begin
            bm_write(1'b1, r, 0, 32'h0000_FFFF);
            bm_write(1'b0, r, 0, 32'h00FF_00FF);
            bm_write(1'b1, r, 1, 32'h0000_0000);
            bm_write(1'b0, r, 1, 32'hFFFF_FFFF);
        end
        pixel(0, 0, 24'h777777, 1'b1, 2'd0, "R8 commit pixel outside cursor");

        // Table walk (R2 R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_x = VEC[i][57:42]; in_y = VEC[i][41:26]; in_rgb = VEC[i][25:2];
            @(negedge clk);
            in_valid = 1'b0;
            check("R1 out_valid", 32'(out_valid), 32'd1);
            check("R1 out_x", 32'(out_x), 32'(VEC[i][57:42]));
            check("R1 out_y", 32'(out_y), 32'(VEC[i][41:26]));
            check("R2/R3/R5 table pixel", 32'(out_rgb), 32'(expect_of(VEC[i][1:0], VEC[i][25:2])));
        end
        @(negedge clk);
        check("R1 out_valid drops", 32'(out_valid), 32'd0);

        // R6 size 64: second word reached, edge clip at 64
        size_sel = 2'b10;
        pixel(132, 50, 24'h102030, 1'b0, 2'd2, "R6 64x64 col 32 fg");
        pixel(163, 113, 24'h102030, 1'b0, 2'd2, "R6 64x64 col 63 row 63");
        pixel(164, 50, 24'h102030, 1'b0, 2'd0, "R6 64x64 right edge");
        size_sel = 2'b00;
        pixel(100, 50, 24'h3C3C3C, 1'b0, 2'd0, "R6 size 00 pass");
        size_sel = 2'b11;
        pixel(116, 50, 24'h3C3C3C, 1'b0, 2'd0, "R6 size 11 pass");
        size_sel = 2'b01;

        // R5 negative origin clipped at left/top
        cur_x = -16'sd10; cur_y = -16'sd5;
        pixel(0, 0, 24'h445566, 1'b0, 2'd0, "R5 negative origin col 10");
        pixel(6, 0, 24'h445566, 1'b0, 2'd2, "R5 negative origin col 16");
        pixel(21, 26, 24'h445566, 1'b0, 2'd3, "R5 negative origin col 31 row 31");
        pixel(22, 0, 24'h445566, 1'b0, 2'd0, "R5 negative origin beyond");
        cur_x = 16'd100; cur_y = 16'd50;

        // R7 hidden cursor
        cur_visible = 1'b0;
        pixel(100, 50, 24'h998877, 1'b0, 2'd0, "R7 hidden invert cell");
        pixel(116, 50, 24'h998877, 1'b0, 2'd0, "R7 hidden fg cell");
        cur_visible = 1'b1;

        // R8 pending write not shown until frame start
        pixel(100, 50, 24'h0F0F0F, 1'b0, 2'd1, "R8 before write");
        bm_write(1'b0, 0, 0, 32'h0000_0000);
        pixel(100, 50, 24'h0F0F0F, 1'b0, 2'd1, "R8 write still pending");
        pixel(100, 50, 24'h0F0F0F, 1'b1, 2'd0, "R8 frame start uses new image");

        // R9 write in the same cycle as frame start
        @(negedge clk);
        bm_wr_en = 1'b1; bm_wr_plane = 1'b0; bm_wr_row = 6'd0; bm_wr_word = 1'b0;
        bm_wr_data = 32'hFFFF_FFFF;
        in_valid = 1'b1; in_sof = 1'b1; in_x = 16'd100; in_y = 16'd50; in_rgb = 24'h0F0F0F;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; bm_wr_en = 1'b0;
        check("R9 colliding write not shown", 32'(out_rgb), 32'h0F0F0F);
        pixel(100, 50, 24'h0F0F0F, 1'b0, 2'd0, "R9 still pending");
        pixel(100, 50, 24'h0F0F0F, 1'b1, 2'd1, "R9 shown at next frame start");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule